// File: doc/BRIEF.md
# SPI NAND Ready Poll and ECC Verdict Unit

After a flash array operation has been launched, this unit watches the device until it reports ready and then tells the controller how healthy the data is. It drives a byte-level command port toward an SPI serializer. Each access is one get-feature transaction: it has a request, an opcode, a one-byte feature address, and a returned byte with a completion strobe and an error flag. The unit reads the status feature again and again, with a fixed idle gap between reads, until the busy bit drops or a programmable number of reads has been used up.

When polling ends, the unit reduces the captured status bits to one of three verdicts: clean, corrected but worth refreshing, or uncorrectable. A scheme select, taken at start, chooses among six field layouts. Each layout has its own thresholds. Two of the layouts also read a second feature register on every poll and join its bits to the status bits to form a 4-bit code. A transport error on any read ends the run at once with the uncorrectable verdict.

Top module: `nand_ecc_poll`

## Requirements
- R1: After reset, `done_o`, `cmd_req_o` and `timeout_o` are 0 and `verdict_o` is 00.
- R2: Every transaction uses opcode 0x0F. `cmd_req_o` stays high, with the address unchanged, until `cmd_done_i` is seen. Status reads use address 0xC0.
- R3: Polling repeats while bit 0 of the status byte is 1 and stops at the first status byte with bit 0 clear. Between two consecutive status reads, `cmd_req_o` is low for at least GAP_CYCLES cycles.
- R4: With scheme 2 or 3, each status read is followed by one read of address 0xF0. Other schemes never access 0xF0.
- R5: Let L be `poll_limit_i`, captured at start. At most max(L,1) status reads occur. If the last permitted read is still busy, `timeout_o` is 1 and the verdict is decoded from that last status byte.
- R6: Scheme 0 (and scheme values 6 and 7) decode status[5:4] this way: 0 or 1 is clean, 2 is uncorrectable, 3 is refresh.
- R7: Scheme 1 decodes status[5:4] this way: 0 is clean, 1 is refresh, 2 and 3 are uncorrectable.
- R8: Schemes 2 and 3 form code = {status[5:4], extra[5:4]}, where extra is the byte read from 0xF0. Codes 0 to 6 are clean, 7 is refresh, and 8 to 15 are uncorrectable. Scheme 3 differs only in that 12 to 15 are refresh.
- R9: Scheme 4 decodes code = status[5:2]. Codes 0 to 6 are clean, 7 and 12 are refresh, and every other code is uncorrectable.
- R10: Scheme 5 decodes code = status[6:4]. Codes 0 to 3 are clean, 4 is refresh, and 5 to 7 are uncorrectable.
- R11: A read that completes with `cmd_err_i` high ends the run with no further reads. The verdict is then 10 and `timeout_o` is 0.
- R12: Verdict encoding is 00 clean, 01 refresh, 10 uncorrectable. `done_o` is a one-cycle pulse. `verdict_o` and `timeout_o` change only with `done_o` and hold until the next one. Scheme and limit are captured at start, and a start during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a poll run (taken only when idle) |
| scheme_i | input | 3 | ECC field layout select |
| poll_limit_i | input | LIMIT_W | Maximum number of status reads (0 acts as 1) |
| cmd_req_o | output | 1 | Transaction request, held until done |
| cmd_op_o | output | 8 | Transaction opcode |
| cmd_addr_o | output | 8 | Feature address |
| cmd_done_i | input | 1 | Transaction complete, data valid |
| cmd_data_i | input | 8 | Returned feature byte |
| cmd_err_i | input | 1 | Transaction failed (valid with done) |
| done_o | output | 1 | One-cycle end-of-run pulse |
| verdict_o | output | 2 | 00 clean, 01 refresh, 10 uncorrectable |
| timeout_o | output | 1 | Run ended with device still busy |

## Verification
The bench builds the unit with GAP_CYCLES = 3 and LIMIT_W = 6. With these values, a timeout needs only a handful of busy replies, and the limit corners 0, exact fit and exhausted can each be run in a few dozen cycles. A short gap keeps multi-poll runs brief while still making the idle spacing between reads measurable. The command port responds after two cycles, so a start issued mid-run lands while a request or gap is pending.

// File: rtl/nep_pkg.sv
package nep_pkg;

  localparam logic [7:0] OP_GET_FEATURE = 8'h0F;
  localparam logic [7:0] FA_STATUS      = 8'hC0;
  localparam logic [7:0] FA_EXTRA       = 8'hF0;

  typedef enum logic [1:0] {
    V_CLEAN   = 2'b00,
    V_REFRESH = 2'b01,
    V_FAIL    = 2'b10
  } verdict_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LAUNCH, S_WAIT, S_EVAL, S_GAP, S_FIN
  } poll_state_e;

  function automatic logic is_dual(input logic [2:0] sch);
    return (sch == 3'd2) || (sch == 3'd3);
  endfunction

  // Reduce the captured bytes to a verdict under a given layout.
  function automatic verdict_e classify(input logic [2:0] sch,
                                        input logic [7:0] st,
                                        input logic [7:0] ex);
    logic [3:0] code;
    verdict_e   v;
    case (sch)
      3'd1: begin
        code = {2'b00, st[5:4]};
        v = (code == 4'd0) ? V_CLEAN : (code == 4'd1) ? V_REFRESH : V_FAIL;
      end
      3'd2, 3'd3: begin
        code = {st[5:4], ex[5:4]};
        if (code < 4'd7)                        v = V_CLEAN;
        else if (code == 4'd7)                  v = V_REFRESH;
        else if (sch == 3'd3 && code >= 4'd12)  v = V_REFRESH;
        else                                    v = V_FAIL;
      end
      3'd4: begin
        code = st[5:2];
        if (code < 4'd7)                        v = V_CLEAN;
        else if (code == 4'd7 || code == 4'd12) v = V_REFRESH;
        else                                    v = V_FAIL;
      end
      3'd5: begin
        code = {1'b0, st[6:4]};
        v = (code < 4'd4) ? V_CLEAN : (code == 4'd4) ? V_REFRESH : V_FAIL;
      end
      default: begin
        code = {2'b00, st[5:4]};
        v = (code == 4'd3) ? V_REFRESH : (code == 4'd2) ? V_FAIL : V_CLEAN;
      end
    endcase
    return v;
  endfunction

endpackage

// File: rtl/nep_gap_timer.sv
module nep_gap_timer #(
  parameter int GAP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);
  localparam int CW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);
  localparam logic [CW-1:0] LOAD_VAL = CW'(GAP_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign expired_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= LOAD_VAL;
      run_q <= 1'b1;
    end else if (expired_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/nep_ecc_decode.sv
module nep_ecc_decode
  import nep_pkg::*;
(
  input  logic [2:0] scheme_i,
  input  logic [7:0] status_i,
  input  logic [7:0] extra_i,
  input  logic       fault_i,
  output verdict_e   verdict_o
);
  verdict_e layout_v;

  assign layout_v  = classify(scheme_i, status_i, extra_i);
  assign verdict_o = fault_i ? V_FAIL : layout_v;
endmodule

// File: rtl/nep_poll_fsm.sv
module nep_poll_fsm
  import nep_pkg::*;
#(
  parameter int LIMIT_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [2:0]         scheme_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               cmd_done_i,
  input  logic [7:0]         cmd_data_i,
  input  logic               cmd_err_i,
  input  logic               gap_expired_i,
  input  verdict_e           verdict_i,
  output logic               cmd_req_o,
  output logic [7:0]         cmd_addr_o,
  output logic               gap_load_o,
  output logic [2:0]         scheme_q_o,
  output logic [7:0]         status_q_o,
  output logic [7:0]         extra_q_o,
  output logic               fault_o,
  output logic               run_start_o,
  output logic               st_launch_o,
  output logic [LIMIT_W-1:0] lim_eff_o,
  output logic               done_o,
  output verdict_e           verdict_o,
  output logic               timeout_o
);
  poll_state_e        state_q;
  logic [2:0]         scheme_q;
  logic [LIMIT_W-1:0] lim_q;
  logic [LIMIT_W-1:0] poll_cnt_q;
  logic               sel_ex_q;
  logic               req_q;
  logic [7:0]         st_q;
  logic [7:0]         ex_q;
  logic               fault_q;
  logic               to_q;
  logic               done_q;
  verdict_e           verdict_q;
  logic               timeout_q;
  logic               limit_hit;

  assign lim_eff_o   = (lim_q == '0) ? LIMIT_W'(1) : lim_q;
  assign limit_hit   = (poll_cnt_q >= lim_eff_o);
  assign run_start_o = (state_q == S_IDLE) && start_i;
  assign st_launch_o = (state_q == S_LAUNCH) && !sel_ex_q;
  assign gap_load_o  = (state_q == S_EVAL) && st_q[0] && !limit_hit;

  assign cmd_req_o  = req_q;
  assign cmd_addr_o = sel_ex_q ? FA_EXTRA : FA_STATUS;
  assign scheme_q_o = scheme_q;
  assign status_q_o = st_q;
  assign extra_q_o  = ex_q;
  assign fault_o    = fault_q;
  assign done_o     = done_q;
  assign verdict_o  = verdict_q;
  assign timeout_o  = timeout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      scheme_q   <= '0;
      lim_q      <= '0;
      poll_cnt_q <= '0;
      sel_ex_q   <= 1'b0;
      req_q      <= 1'b0;
      st_q       <= '0;
      ex_q       <= '0;
      fault_q    <= 1'b0;
      to_q       <= 1'b0;
      done_q     <= 1'b0;
      verdict_q  <= V_CLEAN;
      timeout_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_i) begin
            scheme_q   <= scheme_i;
            lim_q      <= limit_i;
            poll_cnt_q <= '0;
            sel_ex_q   <= 1'b0;
            fault_q    <= 1'b0;
            to_q       <= 1'b0;
            state_q    <= S_LAUNCH;
          end
        end
        S_LAUNCH: begin
          req_q <= 1'b1;
          if (!sel_ex_q) poll_cnt_q <= poll_cnt_q + 1'b1;
          state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (cmd_done_i) begin
            req_q <= 1'b0;
            if (cmd_err_i) begin
              fault_q <= 1'b1;
              state_q <= S_FIN;
            end else if (sel_ex_q) begin
              ex_q     <= cmd_data_i;
              sel_ex_q <= 1'b0;
              state_q  <= S_EVAL;
            end else begin
              st_q <= cmd_data_i;
              if (is_dual(scheme_q)) begin
                sel_ex_q <= 1'b1;
                state_q  <= S_LAUNCH;
              end else begin
                state_q  <= S_EVAL;
              end
            end
          end
        end
        S_EVAL: begin
          if (!st_q[0]) begin
            state_q <= S_FIN;
          end else if (limit_hit) begin
            to_q    <= 1'b1;
            state_q <= S_FIN;
          end else begin
            state_q <= S_GAP;
          end
        end
        S_GAP: begin
          if (gap_expired_i) state_q <= S_LAUNCH;
        end
        S_FIN: begin
          done_q    <= 1'b1;
          verdict_q <= verdict_i;
          timeout_q <= to_q;
          state_q   <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_ecc_poll.sv
module nand_ecc_poll
  import nep_pkg::*;
#(
  parameter int GAP_CYCLES = 4,
  parameter int LIMIT_W    = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [2:0]         scheme_i,
  input  logic [LIMIT_W-1:0] poll_limit_i,
  output logic               cmd_req_o,
  output logic [7:0]         cmd_op_o,
  output logic [7:0]         cmd_addr_o,
  input  logic               cmd_done_i,
  input  logic [7:0]         cmd_data_i,
  input  logic               cmd_err_i,
  output logic               done_o,
  output logic [1:0]         verdict_o,
  output logic               timeout_o
);
  logic               gap_load_w;
  logic               gap_exp_w;
  logic [2:0]         scheme_q_w;
  logic [7:0]         st_q_w;
  logic [7:0]         ex_q_w;
  logic               fault_w;
  logic               run_start_w;
  logic               st_launch_w;
  logic [LIMIT_W-1:0] lim_eff_w;
  verdict_e           verdict_nx_w;
  verdict_e           verdict_w;

  assign cmd_op_o  = OP_GET_FEATURE;
  assign verdict_o = verdict_w;

  nep_poll_fsm #(.LIMIT_W(LIMIT_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .scheme_i      (scheme_i),
    .limit_i       (poll_limit_i),
    .cmd_done_i    (cmd_done_i),
    .cmd_data_i    (cmd_data_i),
    .cmd_err_i     (cmd_err_i),
    .gap_expired_i (gap_exp_w),
    .verdict_i     (verdict_nx_w),
    .cmd_req_o     (cmd_req_o),
    .cmd_addr_o    (cmd_addr_o),
    .gap_load_o    (gap_load_w),
    .scheme_q_o    (scheme_q_w),
    .status_q_o    (st_q_w),
    .extra_q_o     (ex_q_w),
    .fault_o       (fault_w),
    .run_start_o   (run_start_w),
    .st_launch_o   (st_launch_w),
    .lim_eff_o     (lim_eff_w),
    .done_o        (done_o),
    .verdict_o     (verdict_w),
    .timeout_o     (timeout_o)
  );

  nep_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (gap_load_w),
    .expired_o (gap_exp_w)
  );

  nep_ecc_decode u_dec (
    .scheme_i  (scheme_q_w),
    .status_i  (st_q_w),
    .extra_i   (ex_q_w),
    .fault_i   (fault_w),
    .verdict_o (verdict_nx_w)
  );
endmodule

// File: rtl/nand_ecc_poll_chk.sv
module nand_ecc_poll_chk
  import nep_pkg::*;
#(
  parameter int LIMIT_W = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_req_o,
  input logic [7:0]         cmd_addr_o,
  input logic               cmd_done_i,
  input logic               cmd_err_i,
  input logic               done_o,
  input logic [1:0]         verdict_o,
  input logic               timeout_o,
  input logic               run_start_w,
  input logic               st_launch_w,
  input logic [LIMIT_W-1:0] lim_eff_w,
  input logic [2:0]         scheme_q_w
);
  logic [LIMIT_W:0] polls_q;
  logic             err_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      polls_q    <= '0;
      err_seen_q <= 1'b0;
    end else begin
      if (run_start_w)      polls_q <= '0;
      else if (st_launch_w) polls_q <= polls_q + 1'b1;
      if (run_start_w) err_seen_q <= 1'b0;
      else if (cmd_req_o && cmd_done_i && cmd_err_i) err_seen_q <= 1'b1;
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o && !cmd_done_i |=> cmd_req_o && $stable(cmd_addr_o));

  p_addr_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o |-> (cmd_addr_o == FA_STATUS) || (cmd_addr_o == FA_EXTRA));

  p_extra_dual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o && (cmd_addr_o == FA_EXTRA) |-> is_dual(scheme_q_w));

  p_poll_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    polls_q <= {1'b0, lim_eff_w});

  p_err_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_seen_q |-> !st_launch_w);

  p_err_verdict_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && err_seen_q |-> verdict_o == 2'b10 && !timeout_o);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_code_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> verdict_o != 2'b11);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(verdict_o) && $stable(timeout_o));
endmodule

bind nand_ecc_poll nand_ecc_poll_chk #(.LIMIT_W(LIMIT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_req_o   (cmd_req_o),
  .cmd_addr_o  (cmd_addr_o),
  .cmd_done_i  (cmd_done_i),
  .cmd_err_i   (cmd_err_i),
  .done_o      (done_o),
  .verdict_o   (verdict_o),
  .timeout_o   (timeout_o),
  .run_start_w (run_start_w),
  .st_launch_w (st_launch_w),
  .lim_eff_w   (lim_eff_w),
  .scheme_q_w  (scheme_q_w)
);

// File: tb/nand_ecc_poll_bench.sv
`timescale 1ns/1ps
module nand_ecc_poll_bench;
  localparam int GAP = 3;
  localparam int LW  = 6;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [2:0]    scheme_i = '0;
  logic [LW-1:0] poll_limit_i = '0;
  logic          cmd_req_o;
  logic [7:0]    cmd_op_o;
  logic [7:0]    cmd_addr_o;
  logic          cmd_done_i;
  logic [7:0]    cmd_data_i;
  logic          cmd_err_i;
  logic          done_o;
  logic [1:0]    verdict_o;
  logic          timeout_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  int g_nbusy = 0;
  int g_final = 0;
  int g_ex = 0;
  int g_err_at = -1;
  int st_reads = 0;
  int ex_reads = 0;
  int bad_op = 0;
  int min_gap = 1000;
  int last_done = 0;

  always #5 clk = ~clk;

  nand_ecc_poll #(.GAP_CYCLES(GAP), .LIMIT_W(LW)) u_nand_ecc_poll (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .scheme_i(scheme_i),
    .poll_limit_i(poll_limit_i), .cmd_req_o(cmd_req_o), .cmd_op_o(cmd_op_o),
    .cmd_addr_o(cmd_addr_o), .cmd_done_i(cmd_done_i), .cmd_data_i(cmd_data_i),
    .cmd_err_i(cmd_err_i), .done_o(done_o), .verdict_o(verdict_o),
    .timeout_o(timeout_o)
  );

  // Command port model: answers LAT cycles after a request appears.
  initial begin
    int wcnt;
    logic prev_req;
    wcnt = 0;
    prev_req = 1'b0;
    cmd_done_i = 1'b0;
    cmd_data_i = '0;
    cmd_err_i  = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cmd_done_i) begin
        cmd_done_i = 1'b0;
        cmd_err_i  = 1'b0;
        wcnt = 0;
      end else if (cmd_req_o) begin
        if (!prev_req) begin
          if (cmd_op_o != 8'h0F) bad_op++;
          if (cmd_addr_o != 8'hC0 && cmd_addr_o != 8'hF0) bad_op++;
          if (cmd_addr_o == 8'hC0 && st_reads > 0 && (cyc - last_done) < min_gap)
            min_gap = cyc - last_done;
        end
        wcnt++;
        if (wcnt >= LAT) begin
          cmd_done_i = 1'b1;
          if (cmd_addr_o == 8'hC0) begin
            cmd_data_i = (st_reads < g_nbusy) ? 8'(g_final | 1) : 8'(g_final);
            cmd_err_i  = (st_reads == g_err_at);
            st_reads++;
            last_done = cyc;
          end else begin
            cmd_data_i = 8'(g_ex);
            ex_reads++;
          end
        end
      end else begin
        wcnt = 0;
      end
      prev_req = cmd_req_o;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int exp_v(input int s, input int st, input int ex);
    int f;
    case (s)
      1: begin
        f = (st >> 4) & 3;
        if (f == 0) return 0;
        if (f == 1) return 1;
        return 2;
      end
      2, 3: begin
        f = ((st >> 4) & 3) * 4 + ((ex >> 4) & 3);
        if (f <= 6) return 0;
        if (f == 7) return 1;
        if (s == 3 && f >= 12) return 1;
        return 2;
      end
      4: begin
        f = (st >> 2) & 15;
        if (f < 7) return 0;
        if (f == 7 || f == 12) return 1;
        return 2;
      end
      5: begin
        f = (st >> 4) & 7;
        if (f < 4) return 0;
        if (f == 4) return 1;
        return 2;
      end
      default: begin
        f = (st >> 4) & 3;
        if (f == 3) return 1;
        if (f == 2) return 2;
        return 0;
      end
    endcase
  endfunction

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (!done_o && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (!done_o) chk({tag, " done seen"}, 0, 1);
  endtask

  // One poll run; mid_start > 0 re-pulses start (scheme 0, limit 1) that many cycles in.
  task automatic do_run(input string tag, input int s, input int lim, input int nbusy,
                        input int fin, input int ex, input int err_at, input int mid_start);
    int eff, need, e_st, e_ex, e_to, e_v;
    logic dual;
    eff  = (lim == 0) ? 1 : lim;
    need = nbusy + 1;
    dual = (s == 2 || s == 3);
    if (err_at >= 0 && err_at < ((need < eff) ? need : eff)) begin
      e_st = err_at + 1; e_ex = dual ? err_at : 0; e_to = 0; e_v = 2;
    end else begin
      e_st = (need < eff) ? need : eff;
      e_ex = dual ? e_st : 0;
      e_to = (need > eff) ? 1 : 0;
      e_v  = exp_v(s, fin, ex);
    end
    g_nbusy = nbusy; g_final = fin; g_ex = ex; g_err_at = err_at;
    st_reads = 0; ex_reads = 0; bad_op = 0; min_gap = 1000;
    @(negedge clk);
    scheme_i = 3'(s); poll_limit_i = LW'(lim); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (mid_start > 0) begin
      repeat (mid_start) @(negedge clk);
      scheme_i = 3'd0; poll_limit_i = LW'(1); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_done(tag);
    chk({tag, " verdict"}, int'(verdict_o), e_v);
    chk({tag, " timeout"}, int'(timeout_o), e_to);
    chk({tag, " status reads"}, st_reads, e_st);
    chk({tag, " R4 extra reads"}, ex_reads, e_ex);
    chk({tag, " R2 opcode/address"}, bad_op, 0);
    @(negedge clk);
    chk({tag, " R12 done one cycle"}, int'(done_o), 0);
  endtask

  task automatic t_reset_r1();
    chk("R1 done_o after reset", int'(done_o), 0);
    chk("R1 cmd_req_o after reset", int'(cmd_req_o), 0);
    chk("R1 verdict_o after reset", int'(verdict_o), 0);
    chk("R1 timeout_o after reset", int'(timeout_o), 0);
  endtask

  task automatic t_scheme0_r6();
    do_run("R6 s0 code0", 0, 8, 2, 8'h00, 0, -1, 0);
    do_run("R6 s0 code1", 0, 8, 0, 8'h10, 0, -1, 0);
    do_run("R6 s0 code2", 0, 8, 1, 8'h20, 0, -1, 0);
    do_run("R6 s0 code3", 0, 8, 0, 8'h30, 0, -1, 0);
    do_run("R6 s6 code3", 6, 8, 0, 8'h30, 0, -1, 0);
    do_run("R6 s7 code2", 7, 8, 0, 8'h20, 0, -1, 0);
  endtask

  task automatic t_scheme1_r7();
    do_run("R7 s1 code0", 1, 8, 0, 8'h00, 0, -1, 0);
    do_run("R7 s1 code1", 1, 8, 1, 8'h10, 0, -1, 0);
    do_run("R7 s1 code2", 1, 8, 0, 8'h20, 0, -1, 0);
    do_run("R7 s1 code3", 1, 8, 0, 8'h30, 0, -1, 0);
  endtask

  task automatic t_dual_r8();
    do_run("R8 s2 code7", 2, 8, 1, 8'h10, 8'h30, -1, 0);
    do_run("R8 s2 code6", 2, 8, 0, 8'h10, 8'h20, -1, 0);
    do_run("R8 s2 code8", 2, 8, 0, 8'h20, 8'h00, -1, 0);
    do_run("R8 s2 code15", 2, 8, 0, 8'h30, 8'h30, -1, 0);
    do_run("R8 s3 code15", 3, 8, 2, 8'h30, 8'h30, -1, 0);
    do_run("R8 s3 code12", 3, 8, 0, 8'h30, 8'h00, -1, 0);
    do_run("R8 s3 code8", 3, 8, 0, 8'h20, 8'h00, -1, 0);
    do_run("R8 s3 code7", 3, 8, 0, 8'h10, 8'h30, -1, 0);
  endtask

  task automatic t_scheme4_r9();
    do_run("R9 s4 code7", 4, 8, 0, 8'h1C, 0, -1, 0);
    do_run("R9 s4 code12", 4, 8, 1, 8'h30, 0, -1, 0);
    do_run("R9 s4 code6", 4, 8, 0, 8'h18, 0, -1, 0);
    do_run("R9 s4 code8", 4, 8, 0, 8'h20, 0, -1, 0);
    do_run("R9 s4 code15", 4, 8, 0, 8'h3C, 0, -1, 0);
  endtask

  task automatic t_scheme5_r10();
    do_run("R10 s5 code3", 5, 8, 0, 8'h30, 0, -1, 0);
    do_run("R10 s5 code4", 5, 8, 1, 8'h40, 0, -1, 0);
    do_run("R10 s5 code5", 5, 8, 0, 8'h50, 0, -1, 0);
    do_run("R10 s5 code7", 5, 8, 0, 8'h70, 0, -1, 0);
  endtask

  task automatic t_limit_r5();
    do_run("R5 limit3 timeout", 1, 3, 10, 8'h10, 0, -1, 0);
    chk("R3 idle cycles between status reads", (min_gap - 1 >= GAP) ? 1 : 0, 1);
    do_run("R5 limit0 timeout", 0, 0, 5, 8'h20, 0, -1, 0);
    do_run("R5 limit exact fit", 5, 4, 3, 8'h40, 0, -1, 0);
    do_run("R5 dual timeout", 2, 2, 6, 8'h10, 8'h30, -1, 0);
  endtask

  task automatic t_error_r11();
    do_run("R11 error single", 0, 8, 4, 8'h00, 0, 2, 0);
    do_run("R11 error dual", 3, 8, 4, 8'h00, 8'h00, 1, 0);
    do_run("R11 error first read", 1, 8, 0, 8'h00, 0, 0, 0);
  endtask

  task automatic t_restart_hold_r12();
    do_run("R12 start ignored mid run", 1, 8, 4, 8'h10, 0, -1, 6);
    do_run("R12 timeout for hold", 4, 2, 9, 8'h1C, 0, -1, 0);
    scheme_i = 3'd0; poll_limit_i = LW'(1);
    repeat (15) @(negedge clk);
    chk("R12 verdict held", int'(verdict_o), 1);
    chk("R12 timeout held", int'(timeout_o), 1);
    chk("R12 no done while idle", int'(done_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_scheme0_r6();
    t_scheme1_r7();
    t_dual_r8();
    t_scheme4_r9();
    t_scheme5_r10();
    t_limit_r5();
    t_error_r11();
    t_restart_hold_r12();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule